// File: doc/BRIEF.md
# Banked SPI Register Command Decoder

This block is an SPI slave (mode 0, most significant bit first) that turns a stream of bytes into accesses on a small banked control-register file and on an external byte-wide buffer memory. The first byte after chip select falls is a command. Its upper three bits give the operation and its lower five bits give a register address. The bytes that follow carry data in or out. Each new chip-select low period starts a new command.

The register space has five shared registers at addresses 0x1B to 0x1F, which are visible from every bank. Below them are four banks of 27 registers each. The register at 0x1F holds the bank select in its two low bits. Some registers are classed as slow: bank 2 addresses 0x00 to 0x1A, and bank 3 addresses 0x00 to 0x05 and 0x0A. A read of one of these sends a dummy byte before the data byte. In bank 0, two register pairs act as 16-bit buffer pointers, low byte first. Addresses 0x00 and 0x01 form the read pointer, and addresses 0x02 and 0x03 form the write pointer. Buffer commands move these pointers forward one byte per data byte.

The SPI pins are expected to be synchronous to `clk`, which is oversampled against SCK. Buffer reads return data one clock after the request.

Top module: `spi_regcmd_decoder`

## Requirements
- R1: After `rst_n` is low on a clock edge, every register reads 0x00, the bank select is 0, neither buffer request is active, and `spi_miso` is 0 while chip select is high.
- R2: Bits 7:5 of a command byte give the opcode and bits 4:0 give the address. Opcode 000 returns the addressed register on the next byte. Opcode 010 writes the next byte into the register.
- R3: For addresses 0x00 to 0x1A, the bank is given by bits 1:0 of register 0x1F. The same address in different banks holds independent values.
- R4: Addresses 0x1B to 0x1F reach the same five registers whatever the bank select is.
- R5: A read of a slow-class register returns 0x00 on the first byte after the command and the register value on the second byte. Slow class means bank 2 at 0x00 to 0x1A, or bank 3 at 0x00 to 0x05 or 0x0A.
- R6: Opcode 100 ORs the next byte into a non-slow register. Opcode 101 ANDs the complement of the next byte into it.
- R7: Opcodes 100 and 101 that address a slow-class register leave it unchanged.
- R8: Command 0x3A returns buffer bytes on MISO, starting at the read pointer. The pointer advances by one for each data byte that completes.
- R9: Command 0x7A issues one buffer write request per completed data byte, at the write pointer, and then advances that pointer by one.
- R10: Command 0xFF clears every register to 0x00, which includes the bank select and both pointers.
- R11: If chip select rises before the eighth bit of a byte, that byte has no effect on any register, pointer or buffer.
- R12: Command bytes whose opcode is 001, 011, 110 or 111 have no effect, apart from 0x3A, 0x7A and 0xFF. After the response bytes of a command, MISO returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| buf_addr | output | BUF_AW | Buffer address: the write pointer during a write request, otherwise the read pointer |
| buf_rd_req | output | 1 | One-cycle buffer read request |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after `buf_rd_req` |
| buf_wr_req | output | 1 | One-cycle buffer write request |
| buf_wdata | output | 8 | Buffer write data |

## Verification
The assertions assume that SCK, CS and MOSI change only between clock edges and are already synchronous to `clk`. They also assume that each SCK phase lasts at least five clocks, so that a response byte is loaded before the next falling SCK edge, and that buffer data arrives exactly one clock after its request. The bench drives every pin on the falling edge of `clk` and holds each SCK phase for eight clocks. Its buffer model registers read data on the request edge, so every transaction stays inside these assumptions.

// File: rtl/regcmd_pkg.sv
// Shared constants, types and helper functions for the banked SPI
// register command decoder. Assumes a byte-wide register file.
package regcmd_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 5;
    localparam int NUM_BANKS   = 4;
    localparam int BANK_REGS   = 27;
    localparam int COMMON_REGS = 5;
    localparam int BANK_W      = $clog2(NUM_BANKS);
    localparam int CIDX_W      = $clog2(COMMON_REGS);
    localparam int PTR_W       = 2 * BYTE_W;

    localparam logic [2:0] OPC_RDREG = 3'b000;
    localparam logic [2:0] OPC_WRREG = 3'b010;
    localparam logic [2:0] OPC_BSET  = 3'b100;
    localparam logic [2:0] OPC_BCLR  = 3'b101;

    localparam logic [BYTE_W-1:0] CMD_BUF_RD = 8'h3A;
    localparam logic [BYTE_W-1:0] CMD_BUF_WR = 8'h7A;
    localparam logic [BYTE_W-1:0] CMD_RESET  = 8'hFF;

    typedef enum logic [1:0] {WM_LOAD, WM_SET, WM_CLR} wmode_t;

    typedef enum logic [2:0] {
        ST_CMD, ST_RWAIT, ST_RLOAD, ST_WDATA, ST_RBUF, ST_WBUF, ST_IDLE
    } dstate_t;

    // Slow-class registers send a dummy byte before their data.
    function automatic logic is_slow_reg(input logic [BANK_W-1:0] bank,
                                         input logic [ADDR_W-1:0] addr);
        if (addr >= ADDR_W'(BANK_REGS)) return 1'b0;
        if (bank == BANK_W'(2)) return 1'b1;
        if (bank == BANK_W'(3)) return (addr <= 5'h05) || (addr == 5'h0A);
        return 1'b0;
    endfunction

    // New register value for a load, bit-set or bit-clear write.
    function automatic logic [BYTE_W-1:0] apply_op(input logic [BYTE_W-1:0] old,
                                                   input logic [BYTE_W-1:0] data,
                                                   input wmode_t mode);
        case (mode)
            WM_SET:  return old | data;
            WM_CLR:  return old & ~data;
            default: return data;
        endcase
    endfunction
endpackage

// File: rtl/regcmd_spi_shifter.sv
// SPI mode-0 byte shifter. It samples MOSI on rising SCK and shifts MISO
// on falling SCK, most significant bit first. It flags each completed byte.
// Assumes the pins are synchronous to clk and each SCK phase is at least
// five clocks long. Chip select high clears a partly received byte.
module regcmd_spi_shifter
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              miso,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic             sck_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic             sck_rise;
    logic             sck_fall;

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign miso     = tx_sr[BYTE_W-1];
    assign rx_byte  = rx_sr;

    // Keep the previous SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    // Shift bits in and out, count bits and flag completed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
        end else if (cs_n) begin
            bit_cnt  <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], mosi};
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    rx_valid <= 1'b1;
                    tx_sr    <= '0;
                end
            end else if (sck_fall && bit_cnt != '0) begin
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
            if (tx_load) tx_sr <= tx_byte;
        end
    end

    // R11: a completed byte is only ever flagged from a selected period
    a_r11_valid_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!cs_n));
    // R12: MISO stays low once chip select has been high for a clock
    a_r12_miso_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !miso);
endmodule

// File: rtl/regcmd_regfile.sv
// Banked control-register file: four banks of banked registers plus a
// common window. The common register at the top address holds the bank
// select. Bank 0 registers 0..3 double as the buffer read and write
// pointers, low byte first. Assumes at most one write or one pointer
// step per cycle.
module regcmd_regfile
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  wmode_t            wr_mode,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              inc_rptr,
    input  logic              inc_wptr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BANK_W-1:0] bank_sel,
    output logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  wptr
);
    logic                              in_common;
    logic [CIDX_W-1:0]                 cidx;
    logic [BYTE_W-1:0]                 common_q [COMMON_REGS];
    logic [NUM_BANKS-1:0][BYTE_W-1:0]  bank_rd;

    assign in_common = reg_addr >= ADDR_W'(BANK_REGS);
    assign cidx      = CIDX_W'(reg_addr - ADDR_W'(BANK_REGS));
    assign bank_sel  = common_q[COMMON_REGS-1][BANK_W-1:0];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [BYTE_W-1:0] regs [BANK_REGS];

        // Update this bank on writes that select it, and step the pointers in bank 0.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                for (int i = 0; i < BANK_REGS; i++) regs[i] <= '0;
            end else if (wr_en && !in_common && bank_sel == BANK_W'(g)) begin
                regs[reg_addr] <= apply_op(regs[reg_addr], wr_data, wr_mode);
            end else if (g == 0) begin
                if (inc_rptr) {regs[1], regs[0]} <= {regs[1], regs[0]} + PTR_W'(1);
                if (inc_wptr) {regs[3], regs[2]} <= {regs[3], regs[2]} + PTR_W'(1);
            end
        end

        assign bank_rd[g] = in_common ? '0 : regs[reg_addr];

        if (g == 0) begin : g_ptr
            assign rptr = {regs[1], regs[0]};
            assign wptr = {regs[3], regs[2]};
        end
    end

    // Update the common window on writes to its addresses.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int i = 0; i < COMMON_REGS; i++) common_q[i] <= '0;
        end else if (wr_en && in_common) begin
            common_q[cidx] <= apply_op(common_q[cidx], wr_data, wr_mode);
        end
    end

    // Select the read data from the common window or the active bank.
    always_comb begin
        if (in_common) rd_data = common_q[cidx];
        else           rd_data = bank_rd[bank_sel];
    end

    // R10: a soft reset leaves bank 0 selected and both pointers at zero
    a_r10_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank_sel == '0 && rptr == '0 && wptr == '0));
    // R8: each read-pointer step moves it forward by exactly one
    a_r8_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_rptr && !soft_rst) |=> rptr == $past(rptr) + PTR_W'(1));
    // R9: each write-pointer step moves it forward by exactly one
    a_r9_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_wptr && !soft_rst) |=> wptr == $past(wptr) + PTR_W'(1));
endmodule

// File: rtl/regcmd_decoder.sv
// Command sequencer. It decodes the first byte of each chip-select period,
// then drives register writes, response loads and buffer requests for the
// bytes that follow. Assumes buffer read data arrives one clock after its
// request and that chip select high returns it to command decode.
module regcmd_decoder
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output wmode_t            wr_mode,
    output logic              soft_rst,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              inc_rptr,
    output logic              inc_wptr,
    output logic              buf_rd_req,
    output logic              buf_wr_req
);
    dstate_t     state;
    logic        fetch_q;
    logic        land_q;
    logic [2:0]  opcode;
    logic        slow_now;

    assign opcode   = rx_byte[BYTE_W-1:BYTE_W-3];
    assign slow_now = is_slow_reg(bank_sel, rx_byte[ADDR_W-1:0]);

    // Drive the per-byte strobes from the current state and byte flag.
    always_comb begin
        wr_en      = (state == ST_WDATA) && rx_valid;
        soft_rst   = (state == ST_CMD) && rx_valid && (rx_byte == CMD_RESET);
        inc_rptr   = (state == ST_RBUF) && rx_valid;
        buf_wr_req = (state == ST_WBUF) && rx_valid;
        inc_wptr   = buf_wr_req;
        buf_rd_req = fetch_q;
        tx_load    = (state == ST_RLOAD) || land_q;
        tx_byte    = land_q ? buf_rdata : reg_rdata;
    end

    // Sequence each command from its decode to the end of chip select.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            state    <= ST_CMD;
            reg_addr <= '0;
            wr_mode  <= WM_LOAD;
            fetch_q  <= 1'b0;
            land_q   <= 1'b0;
        end else begin
            land_q  <= fetch_q;
            fetch_q <= 1'b0;
            case (state)
                ST_CMD: if (rx_valid) begin
                    reg_addr <= rx_byte[ADDR_W-1:0];
                    if (rx_byte == CMD_RESET) begin
                        state <= ST_IDLE;
                    end else if (rx_byte == CMD_BUF_RD) begin
                        state   <= ST_RBUF;
                        fetch_q <= 1'b1;
                    end else if (rx_byte == CMD_BUF_WR) begin
                        state <= ST_WBUF;
                    end else begin
                        case (opcode)
                            OPC_RDREG: state <= slow_now ? ST_RWAIT : ST_RLOAD;
                            OPC_WRREG: begin
                                wr_mode <= WM_LOAD;
                                state   <= ST_WDATA;
                            end
                            OPC_BSET: begin
                                wr_mode <= WM_SET;
                                state   <= slow_now ? ST_IDLE : ST_WDATA;
                            end
                            OPC_BCLR: begin
                                wr_mode <= WM_CLR;
                                state   <= slow_now ? ST_IDLE : ST_WDATA;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_RWAIT: if (rx_valid) state <= ST_RLOAD;
                ST_RLOAD: state <= ST_IDLE;
                ST_WDATA: if (rx_valid) state <= ST_IDLE;
                ST_RBUF:  if (rx_valid) fetch_q <= 1'b1;
                default:  state <= state;
            endcase
        end
    end

    // R7: bit-field writes never reach a slow-class register
    a_r7_bitop_not_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode != WM_LOAD) |-> !is_slow_reg(bank_sel, reg_addr));
    // R9: buffer reads and writes are never requested together
    a_r9_single_buf_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_req && buf_wr_req));
    // R8: the byte fetched from the buffer is loaded on the next clock
    a_r8_fetch_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_req && !cs_n) |=> (tx_load || cs_n));
endmodule

// File: rtl/spi_regcmd_decoder.sv
// Top level: SPI shifter, command sequencer and banked register file.
// It drives the external buffer address from the write pointer during a
// write request and from the read pointer otherwise. Assumes the SPI pins
// are synchronous to clk and BUF_AW does not exceed the pointer width.
module spi_regcmd_decoder
    import regcmd_pkg::*;
#(
    parameter int BUF_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_rd_req,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr_req,
    output logic [7:0]        buf_wdata
);
    logic              rx_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_byte;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    wmode_t            wr_mode;
    logic              soft_rst;
    logic              inc_rptr;
    logic              inc_wptr;
    logic [BYTE_W-1:0] reg_rdata;
    logic [BANK_W-1:0] bank_sel;
    logic [PTR_W-1:0]  rptr;
    logic [PTR_W-1:0]  wptr;

    regcmd_spi_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    regcmd_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .bank_sel   (bank_sel),
        .reg_rdata  (reg_rdata),
        .buf_rdata  (buf_rdata),
        .reg_addr   (reg_addr),
        .wr_en      (wr_en),
        .wr_mode    (wr_mode),
        .soft_rst   (soft_rst),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .inc_rptr   (inc_rptr),
        .inc_wptr   (inc_wptr),
        .buf_rd_req (buf_rd_req),
        .buf_wr_req (buf_wr_req)
    );

    regcmd_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_mode  (wr_mode),
        .reg_addr (reg_addr),
        .wr_data  (rx_byte),
        .inc_rptr (inc_rptr),
        .inc_wptr (inc_wptr),
        .rd_data  (reg_rdata),
        .bank_sel (bank_sel),
        .rptr     (rptr),
        .wptr     (wptr)
    );

    assign buf_addr  = buf_wr_req ? wptr[BUF_AW-1:0] : rptr[BUF_AW-1:0];
    assign buf_wdata = rx_byte;

    // R1: no buffer request is issued in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!buf_rd_req && !buf_wr_req));
endmodule

// File: tb/tb_spi_regcmd_decoder.sv
module tb_spi_regcmd_decoder;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] buf_addr;
    logic        rd_req;
    logic        wr_req;
    logic [7:0]  rdata = 8'h00;
    logic [7:0]  wdata;

    logic [7:0]  mem [256];
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  txb [16];
    logic [7:0]  rxb [16];
    logic [7:0]  val;

    // bank(2) addr(5) value(8) slow(1)
    localparam logic [15:0] VEC [10] = '{
        {2'd0, 5'h05, 8'hA5, 1'b0},
        {2'd1, 5'h05, 8'h3C, 1'b0},
        {2'd2, 5'h05, 8'h96, 1'b1},
        {2'd3, 5'h05, 8'h69, 1'b1},
        {2'd3, 5'h06, 8'h11, 1'b0},
        {2'd3, 5'h0A, 8'h22, 1'b1},
        {2'd3, 5'h0B, 8'h33, 1'b0},
        {2'd2, 5'h1A, 8'h44, 1'b1},
        {2'd0, 5'h1A, 8'h55, 1'b0},
        {2'd1, 5'h1B, 8'h77, 1'b0}
    };

    always #2.5 clk = ~clk;

    spi_regcmd_decoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (sck),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .buf_addr   (buf_addr),
        .buf_rd_req (rd_req),
        .buf_rdata  (rdata),
        .buf_wr_req (wr_req),
        .buf_wdata  (wdata)
    );

    // Buffer model: registered read data, one clock of latency.
    always @(posedge clk) begin
        if (wr_req) begin
            mem[buf_addr[7:0]] <= wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_req) rdata <= mem[buf_addr[7:0]];
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int nbytes, input int extra_bits);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < nbytes + ((extra_bits > 0) ? 1 : 0); k++) begin
            for (int b = 0; b < ((k < nbytes) ? 8 : extra_bits); b++) begin
                mosi = txb[k][7-b];
                repeat (HALF) @(negedge clk);
                sck = 1'b1;
                rxb[k][7-b] = miso;
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] v);
        txb[0] = {3'b010, a};
        txb[1] = v;
        xfer(2, 0);
    endtask

    task automatic bit_op(input logic [2:0] op, input logic [4:0] a, input logic [7:0] v);
        txb[0] = {op, a};
        txb[1] = v;
        xfer(2, 0);
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic slow, output logic [7:0] v);
        txb[0] = {3'b000, a};
        txb[1] = 8'h00;
        txb[2] = 8'h00;
        xfer(3, 0);
        v = slow ? rxb[2] : rxb[1];
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check("R1 miso idle", {7'd0, miso}, 8'h00);
        rd_reg(5'h1F, 1'b0, val);
        check("R1 bank select", val, 8'h00);
        rd_reg(5'h05, 1'b0, val);
        check("R1 bank0 reg", val, 8'h00);
        check("R1 no writes", 8'(wr_cnt), 8'h00);

        // R2 R3 R4: fill registers across banks from the table
        for (int i = 0; i < 10; i++) begin
            wr_reg(5'h1F, {6'd0, VEC[i][15:14]});
            wr_reg(VEC[i][13:9], VEC[i][8:1]);
        end
        // R2 R3 R5: read each back from its own bank
        for (int i = 0; i < 10; i++) begin
            wr_reg(5'h1F, {6'd0, VEC[i][15:14]});
            rd_reg(VEC[i][13:9], VEC[i][0], val);
            check("R2/R3 readback", val, VEC[i][8:1]);
            if (VEC[i][0]) check("R5 dummy byte", rxb[1], 8'h00);
            else           check("R12 trailing zero", rxb[2], 8'h00);
        end
        // R4: common window seen from another bank
        wr_reg(5'h1F, 8'h03);
        rd_reg(5'h1B, 1'b0, val);
        check("R4 common from bank3", val, 8'h77);
        wr_reg(5'h1F, 8'h00);
        rd_reg(5'h1B, 1'b0, val);
        check("R4 common from bank0", val, 8'h77);

        // R6: bit set and clear on a bank 0 register
        wr_reg(5'h10, 8'hF0);
        bit_op(3'b100, 5'h10, 8'h0F);
        rd_reg(5'h10, 1'b0, val);
        check("R6 bit set", val, 8'hFF);
        bit_op(3'b101, 5'h10, 8'h3C);
        rd_reg(5'h10, 1'b0, val);
        check("R6 bit clear", val, 8'hC3);

        // R7: bit ops ignored on slow class
        wr_reg(5'h1F, 8'h02);
        bit_op(3'b100, 5'h05, 8'h01);
        rd_reg(5'h05, 1'b1, val);
        check("R7 set ignored", val, 8'h96);
        bit_op(3'b101, 5'h05, 8'hFF);
        rd_reg(5'h05, 1'b1, val);
        check("R7 clear ignored", val, 8'h96);

        // R9: buffer write at the write pointer
        wr_reg(5'h1F, 8'h00);
        wr_reg(5'h02, 8'h20);
        wr_reg(5'h03, 8'h00);
        txb[0] = 8'h7A; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
        xfer(4, 0);
        check("R9 write count", 8'(wr_cnt), 8'h03);
        check("R9 mem first", mem[8'h20], 8'h11);
        check("R9 mem last", mem[8'h22], 8'h33);
        rd_reg(5'h02, 1'b0, val);
        check("R9 pointer", val, 8'h23);

        // R8: buffer read from the read pointer
        wr_reg(5'h00, 8'h20);
        wr_reg(5'h01, 8'h00);
        txb[0] = 8'h3A; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
        xfer(4, 0);
        check("R8 byte0", rxb[1], 8'h11);
        check("R8 byte1", rxb[2], 8'h22);
        check("R8 byte2", rxb[3], 8'h33);
        rd_reg(5'h00, 1'b0, val);
        check("R8 pointer", val, 8'h23);

        // R11: aborted data byte and aborted buffer byte
        txb[0] = 8'h45; txb[1] = 8'h00;
        xfer(1, 4);
        rd_reg(5'h05, 1'b0, val);
        check("R11 aborted write", val, 8'hA5);
        txb[0] = 8'h7A; txb[1] = 8'h99;
        xfer(1, 5);
        check("R11 aborted buffer", 8'(wr_cnt), 8'h03);

        // R12: unused opcodes have no effect
        txb[0] = 8'h25; txb[1] = 8'h12;
        xfer(2, 0);
        check("R12 op001 miso", rxb[1], 8'h00);
        txb[0] = 8'hC5; txb[1] = 8'h00;
        xfer(2, 0);
        txb[0] = 8'hE5; txb[1] = 8'h00;
        xfer(2, 0);
        rd_reg(5'h05, 1'b0, val);
        check("R12 reg untouched", val, 8'hA5);

        // R10: soft reset clears everything
        wr_reg(5'h1F, 8'h01);
        txb[0] = 8'hFF;
        xfer(1, 0);
        rd_reg(5'h1F, 1'b0, val);
        check("R10 bank select", val, 8'h00);
        rd_reg(5'h05, 1'b0, val);
        check("R10 bank0 reg", val, 8'h00);
        rd_reg(5'h1B, 1'b0, val);
        check("R10 common reg", val, 8'h00);
        rd_reg(5'h00, 1'b0, val);
        check("R10 read pointer", val, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule